// File: doc/BRIEF.md
# Package Power State Sequencer

This block tracks the package-level low-power state on the bus clock. Starting in the Normal state, it moves toward Stop-Grant once the active-low stop request is held low and the response phase of the stop-grant acknowledge cycle is flagged. From Stop-Grant it can make a short detour into a snoop-service state to answer a bus snoop or catch an interrupt message. It enters Sleep when the active-low sleep request is held. It leaves again when the requests are withdrawn.

While clocks are stopped, the asynchronous event lines are qualified and then latched as sticky single-occurrence bits. The pending interrupt state is reported on a break output. The core clears the latched bits with a one-cycle acknowledge once it is back in Normal. Sleep requests made outside Stop-Grant, bus activity during Sleep and badly ordered wake sequences each raise a one-cycle error pulse.

Top module: `pkg_pwr_seq`

## Requirements
- R1: With `stop_req_n` low, a `grant_ack_rsp` strobe sampled in Normal (code 0) moves `pwr_state` to the entry wait (code 1). Stop-Grant (code 2) is reached exactly ENTRY_DLY (default 20) clock edges after the strobe edge. Releasing `stop_req_n` during the wait returns the state to Normal on the next edge.
- R2: In Stop-Grant, `snp_req` or `intr_msg` moves the state to the snoop-service state (code 3) on the next edge. A snoop stays there until `snp_done` is sampled. An interrupt-only visit returns to Stop-Grant on the following edge. `intr_msg` sampled in states 2 or 3 sets `intr_pend`.
- R3: Sleep (code 4) is entered only from Stop-Grant, and only once `sleep_req_n` has been sampled low on two consecutive edges. A single low sample is not accepted. Sampling `sleep_req_n` high in Sleep returns the state to Stop-Grant.
- R4: `sleep_req_n` sampled low in states 0, 1 or 3 produces a one-cycle `sleep_err` pulse after that edge.
- R5: In Sleep, `snp_req` and `intr_msg` change neither the state nor any pending bit, and each raises `sleep_err`. A snoop on the edge that accepts sleep also raises `sleep_err`.
- R6: An event line counts as an occurrence once it has been sampled high on QUAL_CLKS (default 3) consecutive edges. Shorter pulses are ignored. An occurrence sets `evt_pend` bit i only in states 2 or 3. The bit order is: 0 system-management, 1 init, 2 bus-init, 3 and 4 the two local interrupt lines.
- R7: Repeated occurrences leave one sticky bit. `evt_ack` sampled in Normal clears all event and interrupt pending bits.
- R8: `break_pend` is high exactly when the state is 2 or 3 and any event or interrupt pending bit is set. No enable flag gates it.
- R9: `stop_req_n` sampled high in Stop-Grant returns the state to Normal on the next edge. Leaving Sleep while `stop_req_n` is already high raises `sleep_err`.
- R10: `core_rst` in Sleep sends the state straight to Normal. In any other state it leaves the state unchanged. In every state it clears all pending bits and suppresses `sleep_err`.
- R11: After `rst_n` the state is Normal and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous block reset, active low |
| stop_req_n | input | 1 | Stop-clock request, active low |
| sleep_req_n | input | 1 | Sleep request, active low |
| grant_ack_rsp | input | 1 | Strobe marking the response phase of the stop-grant acknowledge cycle |
| snp_req | input | 1 | Bus snoop request |
| snp_done | input | 1 | Snoop serviced strobe |
| intr_msg | input | 1 | Interrupt message seen on the bus |
| evt_raw | input | NEVT | Asynchronous event lines, active high |
| evt_ack | input | 1 | One-cycle core acknowledge of latched events |
| core_rst | input | 1 | Package reset request |
| pwr_state | output | 3 | Current package state code |
| evt_pend | output | NEVT | Latched event bits |
| intr_pend | output | 1 | Latched bus interrupt |
| break_pend | output | 1 | Pending break event while clocks are stopped |
| sleep_err | output | 1 | Protocol error pulse |

## Verification
The bench looks for off-by-one errors in the entry delay: a design that counts from the wrong edge reaches Stop-Grant one cycle early or late. It drives event pulses one edge shorter than the qualification window, which a loose filter would latch. It repeats events to expose a counter where a sticky bit belongs. It pushes sleep requests of a single sample, bus activity during Sleep, a wake with stop-clock already released, and reset both in Sleep and in Stop-Grant. A design that gets these wrong either lands in the wrong state code, keeps stale pending bits, or misses or invents an error pulse.

// File: rtl/pps_pkg.sv
package pps_pkg;
   typedef enum logic [2:0] {
      PS_NORM  = 3'd0,
      PS_ENTRY = 3'd1,
      PS_SG    = 3'd2,
      PS_SGS   = 3'd3,
      PS_SLP   = 3'd4
   } pstate_e;

   function automatic logic clocks_stopped(input pstate_e s);
      return (s == PS_SG) || (s == PS_SGS);
   endfunction
endpackage

// File: rtl/pps_evt_qual.sv
module pps_evt_qual #(
   parameter int NEVT      = 5,
   parameter int QUAL_CLKS = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NEVT-1:0] raw_i,
   output logic [NEVT-1:0] qual_o
);
   localparam int CW = $clog2(QUAL_CLKS + 1);

   if (QUAL_CLKS < 1) begin : g_bad_qual
      $error("QUAL_CLKS must be at least 1");
   end
   if (NEVT < 1) begin : g_bad_nevt
      $error("NEVT must be at least 1");
   end

   for (genvar i = 0; i < NEVT; i++) begin : g_bit
      logic [CW-1:0] run_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            run_q <= '0;
         else if (!raw_i[i])
            run_q <= '0;
         else if (run_q != CW'(QUAL_CLKS))
            run_q <= run_q + CW'(1);
      end

      assign qual_o[i] = (run_q == CW'(QUAL_CLKS));

      AST_QUAL_NEEDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(qual_o[i]) |-> $past(raw_i[i])); // R6
   end
endmodule

// File: rtl/pps_fsm.sv
module pps_fsm
   import pps_pkg::*;
#(
   parameter int ENTRY_DLY = 20
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    stop_req_n,
   input  logic    sleep_req_n,
   input  logic    grant_ack_rsp,
   input  logic    snp_req,
   input  logic    snp_done,
   input  logic    intr_msg,
   input  logic    core_rst,
   output pstate_e st_o,
   output logic    err_o
);
   localparam int CW = $clog2(ENTRY_DLY + 1);

   if (ENTRY_DLY < 2) begin : g_bad_dly
      $error("ENTRY_DLY must be at least 2");
   end

   pstate_e       st_q, st_d;
   logic [CW-1:0] cnt_q, cnt_d;
   logic          busy_q, busy_d;
   logic          seen_q;
   logic          err_q, err_d;
   logic          slp_now, accept;

   always_comb begin
      st_d    = st_q;
      cnt_d   = cnt_q;
      busy_d  = busy_q;
      err_d   = 1'b0;
      slp_now = !sleep_req_n;
      accept  = slp_now && seen_q;

      if (!core_rst) begin
         if (slp_now && (st_q == PS_NORM || st_q == PS_ENTRY || st_q == PS_SGS))
            err_d = 1'b1;
         if (st_q == PS_SLP && (snp_req || intr_msg))
            err_d = 1'b1;
         if (st_q == PS_SG && accept && snp_req)
            err_d = 1'b1;
         if (st_q == PS_SLP && sleep_req_n && stop_req_n)
            err_d = 1'b1;
      end

      case (st_q)
         PS_NORM: begin
            if (!stop_req_n && grant_ack_rsp) begin
               st_d  = PS_ENTRY;
               cnt_d = CW'(1);
            end
         end
         PS_ENTRY: begin
            if (stop_req_n)
               st_d = PS_NORM;
            else if (cnt_q == CW'(ENTRY_DLY))
               st_d = PS_SG;
            else
               cnt_d = cnt_q + CW'(1);
         end
         PS_SG: begin
            if (stop_req_n)
               st_d = PS_NORM;
            else if (accept)
               st_d = PS_SLP;
            else if (snp_req || intr_msg) begin
               st_d   = PS_SGS;
               busy_d = snp_req;
            end
         end
         PS_SGS: begin
            if (!busy_q || snp_done) begin
               st_d   = PS_SG;
               busy_d = 1'b0;
            end
         end
         PS_SLP: begin
            if (core_rst)
               st_d = PS_NORM;
            else if (sleep_req_n)
               st_d = PS_SG;
         end
         default: st_d = PS_NORM;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= PS_NORM;
         cnt_q  <= '0;
         busy_q <= 1'b0;
         seen_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         st_q   <= st_d;
         cnt_q  <= cnt_d;
         busy_q <= busy_d;
         seen_q <= slp_now;
         err_q  <= err_d;
      end
   end

   assign st_o  = st_q;
   assign err_o = err_q;

   AST_SG_AFTER_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PS_SG && $past(st_q) == PS_ENTRY) |-> $past(cnt_q) == CW'(ENTRY_DLY)); // R1
   AST_SLEEP_FROM_SG: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PS_SLP) |-> ($past(st_q) == PS_SG || $past(st_q) == PS_SLP)); // R3
   AST_SNOOP_IN_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PS_SLP && snp_req && !core_rst) |=> err_q); // R5
   AST_RST_LEAVES_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PS_SLP && core_rst) |=> st_q == PS_NORM); // R10
endmodule

// File: rtl/pps_latch.sv
module pps_latch
   import pps_pkg::*;
#(
   parameter int NEVT = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  pstate_e         st_i,
   input  logic [NEVT-1:0] qual_i,
   input  logic            intr_msg,
   input  logic            evt_ack,
   input  logic            core_rst,
   output logic [NEVT-1:0] pend_o,
   output logic            intr_o
);
   logic [NEVT-1:0] pend_q;
   logic            intr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         intr_q <= 1'b0;
      end else if (core_rst || (st_i == PS_NORM && evt_ack)) begin
         pend_q <= '0;
         intr_q <= 1'b0;
      end else if (clocks_stopped(st_i)) begin
         pend_q <= pend_q | qual_i;
         if (intr_msg)
            intr_q <= 1'b1;
      end
   end

   assign pend_o = pend_q;
   assign intr_o = intr_q;

   AST_SLEEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (st_i == PS_SLP && !core_rst) |=> $stable(pend_q) && $stable(intr_q)); // R5
   AST_NORM_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (st_i == PS_NORM) |=> (pend_q & ~$past(pend_q)) == '0); // R6
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (st_i == PS_NORM && evt_ack) |=> (pend_q == '0 && !intr_q)); // R7
endmodule

// File: rtl/pkg_pwr_seq.sv
module pkg_pwr_seq
   import pps_pkg::*;
#(
   parameter int NEVT      = 5,
   parameter int QUAL_CLKS = 3,
   parameter int ENTRY_DLY = 20
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            stop_req_n,
   input  logic            sleep_req_n,
   input  logic            grant_ack_rsp,
   input  logic            snp_req,
   input  logic            snp_done,
   input  logic            intr_msg,
   input  logic [NEVT-1:0] evt_raw,
   input  logic            evt_ack,
   input  logic            core_rst,
   output logic [2:0]      pwr_state,
   output logic [NEVT-1:0] evt_pend,
   output logic            intr_pend,
   output logic            break_pend,
   output logic            sleep_err
);
   pstate_e         st;
   logic [NEVT-1:0] qual;

   pps_evt_qual #(.NEVT(NEVT), .QUAL_CLKS(QUAL_CLKS)) u_qual (
      .clk(clk), .rst_n(rst_n), .raw_i(evt_raw), .qual_o(qual)
   );

   pps_fsm #(.ENTRY_DLY(ENTRY_DLY)) u_fsm (
      .clk(clk), .rst_n(rst_n), .stop_req_n(stop_req_n), .sleep_req_n(sleep_req_n),
      .grant_ack_rsp(grant_ack_rsp), .snp_req(snp_req), .snp_done(snp_done),
      .intr_msg(intr_msg), .core_rst(core_rst), .st_o(st), .err_o(sleep_err)
   );

   pps_latch #(.NEVT(NEVT)) u_latch (
      .clk(clk), .rst_n(rst_n), .st_i(st), .qual_i(qual), .intr_msg(intr_msg),
      .evt_ack(evt_ack), .core_rst(core_rst), .pend_o(evt_pend), .intr_o(intr_pend)
   );

   assign pwr_state  = st;
   assign break_pend = clocks_stopped(st) && ((|evt_pend) || intr_pend);

   AST_BREAK_QUIET_IN_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 3'd4) |-> !break_pend); // R8
endmodule

// File: tb/sim_pkg_pwr_seq.sv
`timescale 1ns/1ps
module sim_pkg_pwr_seq;
   localparam int NEVT = 5;
   localparam int QC   = 3;
   localparam int DLY  = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic stop_req_n = 1'b1, sleep_req_n = 1'b1, grant_ack_rsp = 1'b0;
   logic snp_req = 1'b0, snp_done = 1'b0, intr_msg = 1'b0;
   logic [NEVT-1:0] evt_raw = '0;
   logic evt_ack = 1'b0, core_rst = 1'b0;
   logic [2:0] pwr_state;
   logic [NEVT-1:0] evt_pend;
   logic intr_pend, break_pend, sleep_err;

   int total = 0;
   int bad = 0;
   bit wd_hit = 1'b0;

   always #5 clk = ~clk;

   pkg_pwr_seq #(.NEVT(NEVT), .QUAL_CLKS(QC), .ENTRY_DLY(DLY)) u0 (
      .clk(clk), .rst_n(rst_n), .stop_req_n(stop_req_n), .sleep_req_n(sleep_req_n),
      .grant_ack_rsp(grant_ack_rsp), .snp_req(snp_req), .snp_done(snp_done),
      .intr_msg(intr_msg), .evt_raw(evt_raw), .evt_ack(evt_ack), .core_rst(core_rst),
      .pwr_state(pwr_state), .evt_pend(evt_pend), .intr_pend(intr_pend),
      .break_pend(break_pend), .sleep_err(sleep_err)
   );

   // behavioural reference model
   int m_st, m_cnt;
   bit m_busy, m_seen, m_err, m_intr;
   int m_run[NEVT];
   logic [NEVT-1:0] m_pend;

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_step();
      logic [NEVT-1:0] q;
      bit slp, acc, stopped, e;
      int ns;
      for (int i = 0; i < NEVT; i++) begin
         q[i] = (m_run[i] == QC);
         m_run[i] = evt_raw[i] ? ((m_run[i] < QC) ? m_run[i] + 1 : QC) : 0;
      end
      slp = !sleep_req_n;
      acc = slp && m_seen;
      stopped = (m_st == 2 || m_st == 3);
      e = 0;
      if (!core_rst) begin
         if (slp && (m_st == 0 || m_st == 1 || m_st == 3)) e = 1;
         if (m_st == 4 && (snp_req || intr_msg)) e = 1;
         if (m_st == 2 && acc && snp_req) e = 1;
         if (m_st == 4 && sleep_req_n && stop_req_n) e = 1;
      end
      if (core_rst || (m_st == 0 && evt_ack)) begin
         m_pend = '0; m_intr = 0;
      end else if (stopped) begin
         m_pend = m_pend | q;
         if (intr_msg) m_intr = 1;
      end
      ns = m_st;
      case (m_st)
         0: if (!stop_req_n && grant_ack_rsp) begin ns = 1; m_cnt = 1; end
         1: if (stop_req_n) ns = 0; else if (m_cnt == DLY) ns = 2; else m_cnt++;
         2: if (stop_req_n) ns = 0;
            else if (acc) ns = 4;
            else if (snp_req || intr_msg) begin ns = 3; m_busy = snp_req; end
         3: if (!m_busy || snp_done) begin ns = 2; m_busy = 0; end
         4: if (core_rst) ns = 0; else if (sleep_req_n) ns = 2;
         default: ns = 0;
      endcase
      m_st = ns;
      m_seen = slp;
      m_err = e;
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_cnt = 0; m_busy = 0; m_seen = 0; m_err = 0; m_intr = 0; m_pend = '0;
         for (int i = 0; i < NEVT; i++) m_run[i] = 0;
      end else begin
         model_step();
         #3;
         check("R2 state vs model", int'(pwr_state), m_st);
         check("R6 event pending vs model", int'(evt_pend), int'(m_pend));
         check("R2 interrupt pending vs model", int'(intr_pend), int'(m_intr));
         check("R8 break vs model", int'(break_pend),
               int'((m_st == 2 || m_st == 3) && (m_pend != 0 || m_intr)));
         check("R4 error vs model", int'(sleep_err), int'(m_err));
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      #3;
   endtask

   task automatic enter_sg();
      @(negedge clk); stop_req_n = 1'b0; grant_ack_rsp = 1'b1;
      @(negedge clk); grant_ack_rsp = 1'b0;
      cyc(DLY);
   endtask

   task automatic hold_evt(input int i, input int n);
      @(negedge clk); evt_raw[i] = 1'b1;
      repeat (n) @(negedge clk);
      evt_raw[i] = 1'b0;
   endtask

   task automatic scenario();
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      cyc(1);
      check("R11 reset state", int'(pwr_state), 0);
      check("R11 reset pending", int'(evt_pend), 0);
      check("R11 reset break", int'(break_pend), 0);
      check("R11 reset error", int'(sleep_err), 0);

      // R1 exact entry timing
      @(negedge clk); stop_req_n = 1'b0; grant_ack_rsp = 1'b1;
      @(negedge clk); grant_ack_rsp = 1'b0;
      cyc(DLY - 1);
      check("R1 still waiting", int'(pwr_state), 1);
      cyc(1);
      check("R1 stop-grant reached", int'(pwr_state), 2);

      // R6 short pulse ignored, long pulse latched once (R7)
      hold_evt(1, QC - 1);
      cyc(3);
      check("R6 short pulse ignored", int'(evt_pend), 0);
      hold_evt(0, QC + 1);
      cyc(2);
      hold_evt(0, QC + 2);
      cyc(2);
      check("R7 single sticky bit", int'(evt_pend), 1);
      check("R8 break with pending event", int'(break_pend), 1);

      // R2 interrupt detour
      @(negedge clk); intr_msg = 1'b1;
      cyc(1);
      check("R2 interrupt enters snoop state", int'(pwr_state), 3);
      @(negedge clk); intr_msg = 1'b0;
      cyc(1);
      check("R2 interrupt returns", int'(pwr_state), 2);
      check("R2 interrupt latched", int'(intr_pend), 1);

      // R2 snoop waits for done
      @(negedge clk); snp_req = 1'b1;
      @(negedge clk); snp_req = 1'b0;
      cyc(3);
      check("R2 snoop held", int'(pwr_state), 3);
      @(negedge clk); snp_done = 1'b1;
      @(negedge clk); snp_done = 1'b0;
      #3;
      check("R2 snoop released", int'(pwr_state), 2);

      // R3 single sample rejected, held request accepted
      @(negedge clk); sleep_req_n = 1'b0;
      @(negedge clk); sleep_req_n = 1'b1;
      cyc(2);
      check("R3 one sample rejected", int'(pwr_state), 2);
      @(negedge clk); sleep_req_n = 1'b0;
      cyc(2);
      check("R3 sleep entered", int'(pwr_state), 4);

      // R5 activity in sleep
      @(negedge clk); snp_req = 1'b1;
      cyc(1);
      check("R5 snoop error", int'(sleep_err), 1);
      check("R5 state kept", int'(pwr_state), 4);
      @(negedge clk); snp_req = 1'b0;
      hold_evt(3, QC + 2);
      cyc(2);
      check("R5 events not latched", int'(evt_pend), 1);

      // R9 leave sleep, then stop-grant to normal
      @(negedge clk); sleep_req_n = 1'b1;
      cyc(1);
      check("R3 back to stop-grant", int'(pwr_state), 2);
      check("R9 orderly wake no error", int'(sleep_err), 0);
      @(negedge clk); stop_req_n = 1'b1;
      cyc(1);
      check("R9 normal", int'(pwr_state), 0);
      check("R8 break low in normal", int'(break_pend), 0);
      check("R7 pending survives", int'(evt_pend), 1);
      @(negedge clk); evt_ack = 1'b1;
      @(negedge clk); evt_ack = 1'b0;
      #3;
      check("R7 ack clears", int'(evt_pend), 0);
      check("R7 ack clears interrupt", int'(intr_pend), 0);

      // R4 illegal sleep in normal
      @(negedge clk); sleep_req_n = 1'b0;
      cyc(1);
      check("R4 illegal sleep error", int'(sleep_err), 1);
      @(negedge clk); sleep_req_n = 1'b1;
      cyc(1);
      check("R4 pulse ends", int'(sleep_err), 0);

      // R1 abort during wait
      @(negedge clk); stop_req_n = 1'b0; grant_ack_rsp = 1'b1;
      @(negedge clk); grant_ack_rsp = 1'b0;
      cyc(4);
      @(negedge clk); stop_req_n = 1'b1;
      cyc(1);
      check("R1 abort to normal", int'(pwr_state), 0);

      // R10 reset in stop-grant
      enter_sg();
      hold_evt(2, QC + 1);
      cyc(1);
      check("R6 bit 2 latched", int'(evt_pend), 4);
      @(negedge clk); core_rst = 1'b1;
      @(negedge clk); core_rst = 1'b0;
      #3;
      check("R10 stays stop-grant", int'(pwr_state), 2);
      check("R10 pending cleared", int'(evt_pend), 0);

      // R10 reset in sleep
      hold_evt(4, QC + 1);
      @(negedge clk); sleep_req_n = 1'b0;
      cyc(2);
      check("R3 sleep again", int'(pwr_state), 4);
      @(negedge clk); core_rst = 1'b1;
      @(negedge clk); core_rst = 1'b0; sleep_req_n = 1'b1; stop_req_n = 1'b1;
      #3;
      check("R10 sleep reset to normal", int'(pwr_state), 0);
      check("R10 sleep reset clears", int'(evt_pend), 0);

      // R9 wake with stop-clock already released
      enter_sg();
      @(negedge clk); sleep_req_n = 1'b0;
      cyc(2);
      @(negedge clk); sleep_req_n = 1'b1; stop_req_n = 1'b1;
      cyc(1);
      check("R9 early stop release error", int'(sleep_err), 1);
      cyc(1);
      check("R9 ends in normal", int'(pwr_state), 0);
      cyc(3);
   endtask

   initial begin
      fork
         scenario();
         begin
            repeat (20000) @(posedge clk);
            wd_hit = 1'b1;
         end
      join_any
      disable fork;
      if (wd_hit) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=1 expected=0");
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule